// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration front end that appears to a host as two byte-wide I/O addresses. The lower one, the index port, picks a register. The upper one, the data port, reads or writes the register that was picked. The whole configuration space stays hidden until the host writes a key byte to the index port the required number of times in a row. A separate exit byte written to the index port hides the space again.

Once the space is open, the block answers a small set of chip-wide registers itself. These are a logical-device selector, a 16-bit device identifier, a revision byte and a 16-bit vendor identifier. Every index at or above the first device-local index goes to a downstream register bus. That bus carries the selected logical-device number, the current index, a write strobe and write data, and it returns read data. The downstream logical devices, such as the general-purpose I/O device (number 0x06), are attached outside this block.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the space is locked, the index register holds 0x00 and the logical-device selector holds 0x00.
- R2: The space opens only after the key byte 0x87 is written to the index port twice in a row while locked. A single key write leaves it locked.
- R3: While locked, an index-port write of any byte other than 0x87 restarts the key count, so the next 0x87 counts as the first key byte again.
- R4: While open, writing 0xAA to the index port locks the space at the next clock edge and leaves the index register unchanged.
- R5: While locked, reads of either port return 0xFF. Data-port writes change no register and raise no downstream write strobe.
- R6: While open, an index-port write of any byte other than 0xAA loads the index register. This includes 0x87. Index-port reads return the index register.
- R7: Index 0x07 is the logical-device selector. It is readable and writable through the data port, and its value drives `dev_ldn`.
- R8: Index 0x20 reads the device identifier high byte and 0x21 its low byte. 0x22 reads the revision. 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these indices are ignored. Any other index below 0x30 except 0x07 reads 0x00.
- R9: For indices 0x30 and above while open, a data-port write raises `dev_wr` for that cycle with `dev_wdata` equal to the written byte, and a data-port read returns `dev_rdata`. Indices below 0x30 never raise `dev_wr`.
- R10: Accesses to any address other than the base and base+1 change no state, and `host_rdata` is 0x00 whenever no port of this block is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the same cycle as host_rd |
| dev_ldn | output | 8 | Selected logical-device number |
| dev_index | output | 8 | Current register index |
| dev_wr | output | 1 | Downstream write strobe |
| dev_wdata | output | 8 | Downstream write byte |
| dev_rdata | input | 8 | Downstream read byte for the current index |

## Verification
The bench targets the key sequence at its edges. It writes a lone key byte, breaks a key pair with a different byte, and sends key bytes to an unrelated address. A counter that does not restart, or a decode that is too loose, would unlock the space too early. It checks that the exit byte does not overwrite the index and that 0x87 written while open is stored as an index. It also checks that data-port writes while locked leave the selector intact. Writes to the identification indices and to indices just below the device-local range must not reach the selector, the identifiers or the downstream strobe.

// File: rtl/keyed_cfg_port_pkg.sv
package keyed_cfg_port_pkg;

    localparam logic [7:0] KEY_BYTE   = 8'h87;
    localparam logic [7:0] EXIT_BYTE  = 8'hAA;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_DID_HI = 8'h20;
    localparam logic [7:0] IDX_DID_LO = 8'h21;
    localparam logic [7:0] IDX_REV    = 8'h22;
    localparam logic [7:0] IDX_VID_HI = 8'h23;
    localparam logic [7:0] IDX_VID_LO = 8'h24;
    localparam logic [7:0] LOCAL_BASE = 8'h30;
    localparam logic [15:0] VENDOR_ID = 16'h1934;
    localparam logic [7:0] LOCKED_READ = 8'hFF;

    typedef enum logic {
        SPACE_LOCKED = 1'b0,
        SPACE_OPEN   = 1'b1
    } space_state_t;

    typedef struct packed {
        logic       idx_wr;
        logic       idx_rd;
        logic       dat_wr;
        logic       dat_rd;
        logic [7:0] wdata;
    } host_req_t;

    function automatic logic is_chip_level(input logic [7:0] idx);
        return idx < LOCAL_BASE;
    endfunction

endpackage

// File: rtl/keyed_cfg_port_key_fsm.sv
module keyed_cfg_port_key_fsm
    import keyed_cfg_port_pkg::*;
#(
    parameter int KEY_REPEAT = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    output logic      open_o
);
    localparam int CNT_W = $clog2(KEY_REPEAT + 1);
    localparam logic [CNT_W-1:0] LAST_KEY = CNT_W'(KEY_REPEAT - 1);

    space_state_t     state_q;
    logic [CNT_W-1:0] key_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SPACE_LOCKED;
            key_cnt_q <= '0;
        end else if (req.idx_wr) begin
            if (state_q == SPACE_LOCKED) begin
                if (req.wdata == KEY_BYTE) begin
                    if (key_cnt_q == LAST_KEY) begin
                        state_q   <= SPACE_OPEN;
                        key_cnt_q <= '0;
                    end else begin
                        key_cnt_q <= key_cnt_q + 1'b1;
                    end
                end else begin
                    key_cnt_q <= '0;
                end
            end else if (req.wdata == EXIT_BYTE) begin
                state_q   <= SPACE_LOCKED;
                key_cnt_q <= '0;
            end
        end
    end

    assign open_o = (state_q == SPACE_OPEN);

endmodule

// File: rtl/keyed_cfg_port_chip_regs.sv
module keyed_cfg_port_chip_regs
    import keyed_cfg_port_pkg::*;
#(
    parameter logic [15:0] DEVICE_ID = 16'h1010,
    parameter logic [7:0]  REVISION  = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] ldn_o,
    output logic [7:0] rdata_o
);
    logic [7:0] ldn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ldn_q <= 8'h00;
        end else if (wr_en && index == IDX_LDN) begin
            ldn_q <= wdata;
        end
    end

    always_comb begin
        unique case (index)
            IDX_LDN:    rdata_o = ldn_q;
            IDX_DID_HI: rdata_o = DEVICE_ID[15:8];
            IDX_DID_LO: rdata_o = DEVICE_ID[7:0];
            IDX_REV:    rdata_o = REVISION;
            IDX_VID_HI: rdata_o = VENDOR_ID[15:8];
            IDX_VID_LO: rdata_o = VENDOR_ID[7:0];
            default:    rdata_o = 8'h00;
        endcase
    end

    assign ldn_o = ldn_q;

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import keyed_cfg_port_pkg::*;
#(
    parameter int                 ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR  = 16'h002E,
    parameter logic [15:0]        DEVICE_ID  = 16'h1010,
    parameter logic [7:0]         REVISION   = 8'h01,
    parameter int                 KEY_REPEAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [7:0]        dev_ldn,
    output logic [7:0]        dev_index,
    output logic              dev_wr,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    host_req_t  req;
    logic       unlocked;
    logic [7:0] index_q;
    logic [7:0] chip_rdata;
    logic       chip_level;

    always_comb begin
        req.idx_wr = host_wr && (host_addr == BASE_ADDR);
        req.idx_rd = host_rd && (host_addr == BASE_ADDR);
        req.dat_wr = host_wr && (host_addr == DATA_ADDR);
        req.dat_rd = host_rd && (host_addr == DATA_ADDR);
        req.wdata  = host_wdata;
    end

    keyed_cfg_port_key_fsm #(
        .KEY_REPEAT (KEY_REPEAT)
    ) u_key (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .open_o (unlocked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
        end else if (req.idx_wr && unlocked && host_wdata != EXIT_BYTE) begin
            index_q <= host_wdata;
        end
    end

    assign chip_level = is_chip_level(index_q);

    keyed_cfg_port_chip_regs #(
        .DEVICE_ID (DEVICE_ID),
        .REVISION  (REVISION)
    ) u_chip (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.dat_wr && unlocked),
        .index   (index_q),
        .wdata   (host_wdata),
        .ldn_o   (dev_ldn),
        .rdata_o (chip_rdata)
    );

    always_comb begin
        if (req.idx_rd) begin
            host_rdata = unlocked ? index_q : LOCKED_READ;
        end else if (req.dat_rd) begin
            if (!unlocked)       host_rdata = LOCKED_READ;
            else if (chip_level) host_rdata = chip_rdata;
            else                 host_rdata = dev_rdata;
        end else begin
            host_rdata = 8'h00;
        end
    end

    assign dev_index = index_q;
    assign dev_wr    = req.dat_wr && unlocked && !chip_level;
    assign dev_wdata = host_wdata;

endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic [7:0]        dev_ldn,
    input logic [7:0]        dev_index,
    input logic              dev_wr,
    input logic              unlocked
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    logic iw, dw, dr;
    assign iw = host_wr && host_addr == BASE_ADDR;
    assign dw = host_wr && host_addr == DATA_ADDR;
    assign dr = host_rd && host_addr == DATA_ADDR;

    AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(iw && host_wdata == 8'h87)); // R2

    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        (unlocked && iw && host_wdata == 8'hAA) |=> !unlocked); // R4

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && dr) |-> host_rdata == 8'hFF); // R5

    AST_LOCKED_LDN_HELD: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(dev_ldn)); // R5

    AST_DEVWR_GATED: assert property (@(posedge clk) disable iff (rst)
        dev_wr |-> (unlocked && dw && dev_index >= 8'h30)); // R9

    AST_VENDOR_HI_READ: assert property (@(posedge clk) disable iff (rst)
        (unlocked && dr && dev_index == 8'h23) |-> host_rdata == 8'h19); // R8

    AST_FOREIGN_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!iw && !dw) |=> ($stable(unlocked) && $stable(dev_index) && $stable(dev_ldn))); // R10

endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .dev_ldn    (dev_ldn),
    .dev_index  (dev_index),
    .dev_wr     (dev_wr),
    .unlocked   (unlocked)
);

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
    localparam logic [15:0] BASE = 16'h002E;
    localparam logic [15:0] DATA = 16'h002F;
    localparam logic [15:0] DID  = 16'h1010;
    localparam logic [7:0]  REV  = 8'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata, dev_ldn, dev_index, dev_wdata, dev_rdata;
    logic        dev_wr;

    int errors = 0;
    int checks = 0;

    // model state
    bit   m_locked = 1'b1;
    int   m_cnt = 0;
    logic [7:0] m_idx = 8'h00;
    logic [7:0] m_ldn = 8'h00;

    always #10 clk = ~clk;

    assign dev_rdata = dev_index ^ 8'h5A;

    keyed_cfg_port #(
        .ADDR_W(16), .BASE_ADDR(BASE), .DEVICE_ID(DID),
        .REVISION(REV), .KEY_REPEAT(2)
    ) uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_ldn(dev_ldn), .dev_index(dev_index), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] chip_value(input logic [7:0] i);
        case (i)
            8'h07: return m_ldn;
            8'h20: return DID[15:8];
            8'h21: return DID[7:0];
            8'h22: return REV;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(input string tag, input logic [15:0] a,
                        input logic w, input logic r, input logic [7:0] d);
        logic [7:0] exp_rd;
        logic       exp_dw;
        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
        #5;
        exp_rd = 8'h00;
        if (r && a == BASE)      exp_rd = m_locked ? 8'hFF : m_idx;
        else if (r && a == DATA) exp_rd = m_locked ? 8'hFF :
                                          (m_idx < 8'h30 ? chip_value(m_idx) : (m_idx ^ 8'h5A));
        exp_dw = w && a == DATA && !m_locked && m_idx >= 8'h30;
        check(tag, "host_rdata", host_rdata, exp_rd);
        check(tag, "dev_wr", {7'b0, dev_wr}, {7'b0, exp_dw});
        check(tag, "dev_index", dev_index, m_idx);
        check(tag, "dev_ldn", dev_ldn, m_ldn);
        if (exp_dw) check(tag, "dev_wdata", dev_wdata, d);
        @(posedge clk);
        #1;
        if (w && a == BASE) begin
            if (m_locked) begin
                if (d == 8'h87) begin
                    m_cnt++;
                    if (m_cnt == 2) begin m_locked = 1'b0; m_cnt = 0; end
                end else m_cnt = 0;
            end else if (d == 8'hAA) m_locked = 1'b1;
            else m_idx = d;
        end
        if (w && a == DATA && !m_locked && m_idx == 8'h07) m_ldn = d;
    endtask

    task automatic wi(input string t, input logic [7:0] d); step(t, BASE, 1, 0, d); endtask
    task automatic wd(input string t, input logic [7:0] d); step(t, DATA, 1, 0, d); endtask
    task automatic ri(input string t); step(t, BASE, 0, 1, 8'h00); endtask
    task automatic rd(input string t); step(t, DATA, 0, 1, 8'h00); endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        step("R1_reset", BASE, 0, 0, 8'h00);
        ri("R5_locked_index_read");
        rd("R5_locked_data_read");
        wd("R5_locked_data_write", 8'h77);
        // R2: lone key stays locked
        wi("R2_first_key", 8'h87);
        ri("R2_one_key_locked");
        wi("R2_second_key", 8'h87);
        ri("R1_index_after_unlock");
        wi("R7_sel_ldn", 8'h07);
        rd("R1_ldn_reset");
        wd("R7_write_ldn", 8'h06);
        rd("R7_read_ldn");
        // R8 identification
        wi("R8", 8'h20); rd("R8_did_hi");
        wi("R8", 8'h21); rd("R8_did_lo");
        wi("R8", 8'h22); rd("R8_rev");
        wi("R8", 8'h23); rd("R8_vid_hi");
        wd("R8_write_ignored", 8'h55); rd("R8_vid_hi_after_write");
        wi("R8", 8'h24); rd("R8_vid_lo");
        wi("R8", 8'h2F); wd("R9_below_local_no_strobe", 8'h3C); rd("R8_other_zero");
        // R9 downstream
        wi("R9", 8'h30); wd("R9_dev_write", 8'hC3); rd("R9_dev_read");
        wi("R9", 8'hF1); wd("R9_dev_write_hi", 8'h0F); rd("R9_dev_read_hi");
        // R6: key byte stored as index while open
        wi("R6_key_as_index", 8'h87); ri("R6_index_read");
        // R4: exit leaves index, locks
        wi("R7", 8'h07);
        wi("R4_exit", 8'hAA);
        ri("R4_locked_index_read");
        rd("R4_locked_data_read");
        wd("R5_locked_ldn_write", 8'h11);
        step("R5_ldn_held", BASE, 0, 0, 8'h00);
        // R3: broken key pair
        wi("R3_key", 8'h87); wi("R3_break", 8'h55); wi("R3_key_again", 8'h87);
        ri("R3_still_locked");
        wi("R3_pair_done", 8'h87);
        ri("R4_index_kept");
        rd("R5_ldn_unchanged");
        // R10: foreign addresses
        wi("R4", 8'hAA);
        step("R10_foreign_key", 16'h0030, 1, 0, 8'h87);
        step("R10_foreign_key", 16'h0030, 1, 0, 8'h87);
        ri("R10_still_locked");
        step("R10_foreign_read", 16'h004E, 0, 1, 8'h00);
        wi("R2", 8'h87); wi("R2", 8'h87);
        step("R10_foreign_write_open", 16'h002D, 1, 0, 8'h22);
        step("R10_foreign_read_open", 16'h0030, 0, 1, 8'h00);
        ri("R10_index_intact");
        step("R1_idle", BASE, 0, 0, 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule